// File: doc/BRIEF.md
# Key-Protected Oscillator Control Register

This block is a small register slice on a simple synchronous bus. It has a 16-bit key register and a 16-bit oscillator control and status register. The control register changes only when the write comes directly after the exact unlock key has been written to the key register. Any other bus write in between cancels the unlock. A write that reaches the control register uses up the unlock, so each protected update needs its own key write.

The control register holds one enable bit for each of three oscillators: low-frequency, high-frequency and high-frequency crystal. It also reports three read-only ready flags. The analog oscillators sit outside the block. Each one is represented by a one-cycle `stable` pulse input. A ready flag sets on the first such pulse while its oscillator is enabled and then stays set. It does not track later loss of stability. Turning the oscillator off clears its flag.

Top module: `osc_key_regs`

## Requirements
- R1: After reset the key register reads 0x0000 and the control register reads 0x0003. Control bit 0 is the low-frequency enable, bit 1 the high-frequency enable and bit 2 the crystal enable.
- R2: A read with `rd_en` high returns data on `rdata` in the following cycle. Address 0x0A0C returns the last value written to the key register. Address 0x0A10 returns the control register, with bits [15:11] and [7:3] reading 0. Any other address returns 0x0000.
- R3: Writing 0xCB14 to 0x0A0C unlocks the control register. The next bus write, if it targets 0x0A10, loads bits [2:0] from `wdata`.
- R4: A write to 0x0A10 while locked changes nothing.
- R5: A write to any address other than 0x0A0C or 0x0A10, made after the key write, locks the control register again.
- R6: Writing any value other than 0xCB14 to the key register leaves the control register locked.
- R7: A write that reaches the control register uses up the unlock. A second control write without a new key write is ignored.
- R8: Status bit 8 reports the low-frequency oscillator, bit 9 the high-frequency oscillator and bit 10 the crystal. `stable[i]` maps to bit 8+i. A bit sets in the cycle after a pulse on its `stable` input while its enable is 1. A pulse while the enable is 0 has no effect.
- R9: A set status bit stays 1 with no further `stable` pulses.
- R10: Clearing an enable bit clears its status bit. After the oscillator is enabled again, the bit stays 0 until a new `stable` pulse arrives.
- R11: Write data in control bits [15:3], including the status bits, is discarded.
- R12: Bus reads do not change the unlock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 16 | Byte address |
| wdata | input | 16 | Write data |
| stable | input | 3 | Oscillator stable pulses (0 low-freq, 1 high-freq, 2 crystal) |
| rdata | output | 16 | Registered read data |

## Verification
The assertions assume that each bus cycle asserts at most one of `wr_en` and `rd_en`. They also assume that `stable` pulses last one cycle and are raised only between bus accesses. The bench drives every access and every pulse as a single-cycle strobe on the falling edge, and never overlaps a read with a write. The lock assertions also assume that `addr` and `wdata` are known whenever `wr_en` is high, which the bench ensures by always loading both with the strobe.

// File: rtl/osc_key_pkg.sv
package osc_key_pkg;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 16;
    localparam int N_OSC      = 3;
    localparam int STAT_LSB   = 8;
    localparam logic [ADDR_W-1:0] KEY_ADDR   = 16'h0A0C;
    localparam logic [ADDR_W-1:0] CTRL_ADDR  = 16'h0A10;
    localparam logic [DATA_W-1:0] UNLOCK_KEY = 16'hCB14;
    localparam logic [N_OSC-1:0]  EN_RESET   = 3'b011;

    typedef enum logic [1:0] {SEL_NONE, SEL_KEY, SEL_CTRL} reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        if (a == KEY_ADDR)  return SEL_KEY;
        if (a == CTRL_ADDR) return SEL_CTRL;
        return SEL_NONE;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input logic [N_OSC-1:0] en,
                                                    input logic [N_OSC-1:0] rdy);
        logic [DATA_W-1:0] v;
        v = '0;
        v[N_OSC-1:0] = en;
        v[STAT_LSB +: N_OSC] = rdy;
        return v;
    endfunction
endpackage

// File: rtl/osc_key_lock.sv
module osc_key_lock
    import osc_key_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output logic     unlocked
);
    logic unl_q;

    // Every write re-evaluates the lock: only a matching key write leaves it open.
    always_ff @(posedge clk) begin
        if (rst)
            unl_q <= 1'b0;
        else if (req.wr)
            unl_q <= (req.sel == SEL_KEY) && (req.wdata == UNLOCK_KEY);
    end

    assign unlocked = unl_q;

    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_KEY && req.wdata == UNLOCK_KEY) |=> unlocked); // R3
    AST_FOREIGN_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_NONE) |=> !unlocked); // R5
    AST_BAD_KEY_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_KEY && req.wdata != UNLOCK_KEY) |=> !unlocked); // R6
    AST_CTRL_CONSUMES: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_CTRL) |=> !unlocked); // R7
    AST_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (!req.wr && req.rd) |=> $stable(unlocked)); // R12
endmodule

// File: rtl/osc_ready_flags.sv
module osc_ready_flags
    import osc_key_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_OSC-1:0] en_next,
    input  logic [N_OSC-1:0] en_cur,
    input  logic [N_OSC-1:0] stable,
    output logic [N_OSC-1:0] ready
);
    logic [N_OSC-1:0] rdy_q;

    for (genvar i = 0; i < N_OSC; i++) begin : g_osc
        always_ff @(posedge clk) begin
            if (rst)
                rdy_q[i] <= 1'b0;
            else if (!en_next[i])
                rdy_q[i] <= 1'b0;
            else if (stable[i] && en_cur[i])
                rdy_q[i] <= 1'b1;
        end

        AST_FLAG_NEEDS_PULSE: assert property (@(posedge clk) disable iff (rst)
            $rose(rdy_q[i]) |-> $past(stable[i])); // R8
        AST_FLAG_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
            !en_cur[i] |-> !rdy_q[i]); // R10
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
            (rdy_q[i] && en_next[i]) |=> rdy_q[i]); // R9
    end

    assign ready = rdy_q;
endmodule

// File: rtl/osc_key_regs.sv
module osc_key_regs
    import osc_key_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N_OSC-1:0]  stable,
    output logic [DATA_W-1:0] rdata
);
    bus_req_t          req;
    logic              unlocked;
    logic              ctrl_take;
    logic [DATA_W-1:0] key_q;
    logic [N_OSC-1:0]  en_q;
    logic [N_OSC-1:0]  en_d;
    logic [N_OSC-1:0]  ready;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        req.wr    = wr_en;
        req.rd    = rd_en;
        req.sel   = decode(addr);
        req.wdata = wdata;
    end

    osc_key_lock u_lock (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .unlocked (unlocked)
    );

    assign ctrl_take = req.wr && (req.sel == SEL_CTRL) && unlocked;
    assign en_d      = ctrl_take ? req.wdata[N_OSC-1:0] : en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= '0;
            en_q  <= EN_RESET;
        end else begin
            if (req.wr && req.sel == SEL_KEY)
                key_q <= req.wdata;
            en_q <= en_d;
        end
    end

    osc_ready_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .en_next (en_d),
        .en_cur  (en_q),
        .stable  (stable),
        .ready   (ready)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (req.rd) begin
            unique case (req.sel)
                SEL_KEY:  rdata_q <= key_q;
                SEL_CTRL: rdata_q <= pack_ctrl(en_q, ready);
                default:  rdata_q <= '0;
            endcase
        end
    end

    assign rdata = rdata_q;

    AST_LOCKED_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_CTRL && !unlocked) |=> $stable(en_q)); // R4
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(req.rd) && $past(req.sel) == SEL_CTRL) |-> (rdata[15:11] == 5'd0 && rdata[7:3] == 5'd0)); // R2
    AST_EN_ONLY_BY_UNLOCK: assert property (@(posedge clk) disable iff (rst)
        !$stable(en_q) |-> $past(unlocked) && $past(req.wr)); // R3
endmodule

// File: tb/sim_osc_key_regs.sv
module sim_osc_key_regs;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [2:0]  stable = '0;
    logic [15:0] rdata;

    int checks = 0;
    int fails  = 0;
    bit pend   = 1'b0;
    bit done   = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    osc_key_regs u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .stable(stable), .rdata(rdata)
    );

    always @(posedge clk) pend <= rd_en;

    // Monitor: compares each completed read against the scoreboard queue.
    always @(negedge clk) begin
        if (pend && exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdata !== e) begin
                fails++;
                $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [15:0] e, input string t);
        @(negedge clk); rd_en = 1'b1; addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic pulse(input int i);
        @(negedge clk); stable[i] = 1'b1;
        @(negedge clk); stable = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: finished=0 expected=1");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd(16'h0A0C, 16'h0000, "R1 key reset");
        rd(16'h0A10, 16'h0003, "R1 ctrl reset");
        rd(16'h0A14, 16'h0000, "R2 unmapped read");
        wr(16'h0A10, 16'h0000);
        rd(16'h0A10, 16'h0003, "R4 locked write ignored");
        wr(16'h0A0C, 16'hCB14);
        wr(16'h0A10, 16'h0007);
        rd(16'h0A10, 16'h0007, "R3 unlocked write");
        rd(16'h0A0C, 16'hCB14, "R2 key readback");
        wr(16'h0A10, 16'h0000);
        rd(16'h0A10, 16'h0007, "R7 unlock consumed");
        wr(16'h0A0C, 16'hCB14);
        wr(16'h0100, 16'h0000);
        wr(16'h0A10, 16'h0000);
        rd(16'h0A10, 16'h0007, "R5 foreign write cancels");
        wr(16'h0A0C, 16'h1234);
        wr(16'h0A10, 16'h0000);
        rd(16'h0A10, 16'h0007, "R6 wrong key");
        rd(16'h0A0C, 16'h1234, "R2 key holds wrong value");
        wr(16'h0A0C, 16'hCB14);
        rd(16'h0A10, 16'h0007, "R12 read while unlocked");
        wr(16'h0A10, 16'hFFFD);
        rd(16'h0A10, 16'h0005, "R11 R12 high bits discarded");
        pulse(1);
        rd(16'h0A10, 16'h0005, "R8 pulse while disabled");
        pulse(0);
        rd(16'h0A10, 16'h0105, "R8 low-freq ready");
        pulse(2);
        rd(16'h0A10, 16'h0505, "R8 crystal ready");
        repeat (10) @(negedge clk);
        rd(16'h0A10, 16'h0505, "R9 sticky");
        wr(16'h0A0C, 16'hCB14);
        wr(16'h0A10, 16'h0004);
        rd(16'h0A10, 16'h0404, "R10 disable clears");
        wr(16'h0A0C, 16'hCB14);
        wr(16'h0A10, 16'h0005);
        rd(16'h0A10, 16'h0405, "R10 re-enable stays clear");
        pulse(0);
        rd(16'h0A10, 16'h0505, "R10 new pulse sets");
        wr(16'h0A10, 16'h0000);
        rd(16'h0A10, 16'h0505, "R4 locked write keeps status");
        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule